// File: doc/BRIEF.md
# Load/Store Data Translation Stage

This block is one registered stage in a processor's memory path. It rearranges the bits or bytes of load and store data according to a 4-bit slot selector chosen per access. For a load it takes the raw bytes read from memory, the access size, a signed flag and the selector. It returns the translated value extended to 64 bits, or a trap with a cause code. For a store it takes the register value, the size and the selector. It returns the translated store bytes with their byte enables.

Each slot applies one fixed rearrangement. Three slots work on every byte on its own and accept any access size. The other nine are locked to one access size, and any other pairing traps, as does a reserved selector. A bypass input forces the identity transform for accesses that must pass untranslated. Address generation, the memory itself and the storage of selectors belong to other blocks.

The stage has a valid/ready handshake at its input and at its output. An accepted access appears at the output one cycle later and is held there until the consumer takes it.

Top module: `mem_xlate_stage`

## Requirements
- R1: After reset, out_valid is low and in_ready is high.
- R2: The selector values give these transforms: 0 identity, 1 nibble swap in each byte, 2 bit reverse in each byte, 3 byte swap over 2 bytes, 4 byte swap over 4 bytes, 5 byte swap over 8 bytes, 6 swap of the two halfwords of 4 bytes, 7 reversal of the four halfwords of 8 bytes, 8 swap of the two words of 8 bytes, 9 bit reverse over 16 bits, 10 bit reverse over 32 bits, 11 bit reverse over 64 bits.
- R3: Selectors 0, 1 and 2 are legal for every access size. in_size encodes 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes.
- R4: Selectors 3 and 9 are legal only with 2 bytes. Selectors 4, 6 and 10 are legal only with 4 bytes. Selectors 5, 7, 8 and 11 are legal only with 8 bytes. Any other pairing traps with out_cause = 32.
- R5: Selectors 12 to 15 trap with out_cause = 33 at every access size.
- R6: On a load, the data is translated first and extended afterwards. The extension is from bit 8*size_bytes-1 when in_signed is 1 and size is below 8 bytes, and zero-filled otherwise.
- R7: On a store, in_data is cut to the access size and then translated. out_byte_en is 0x01, 0x03, 0x0F or 0xFF for 1, 2, 4 or 8 bytes, and out_mem_we is high.
- R8: For a trapping access, out_trap is high and out_data, out_byte_en, out_reg_we and out_mem_we are all zero. For an access that does not trap, out_trap and out_cause are zero.
- R9: A load with in_rd_zero high still goes through the legality check and traps as usual, but out_reg_we stays low.
- R10: When in_bypass is high, the identity transform is used and no trap is raised, whatever the selector.
- R11: Every legal selector is its own inverse. Storing a store result again with the same selector and size gives back the truncated original.
- R12: An accepted access appears at the output one cycle later. The output stays stable while out_ready is low, and in_ready = !out_valid || out_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Access offered |
| in_ready | output | 1 | Stage can take an access |
| in_is_store | input | 1 | 1 = store, 0 = load |
| in_size | input | 2 | Access size code (0:1B, 1:2B, 2:4B, 3:8B) |
| in_signed | input | 1 | Sign-extend a load |
| in_slot | input | 4 | Transform selector |
| in_bypass | input | 1 | Force identity, no checks |
| in_rd_zero | input | 1 | Load targets register 0 |
| in_data | input | 64 | Load bytes or store register value |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes result |
| out_is_store | output | 1 | Result belongs to a store |
| out_data | output | 64 | Translated load value or store bytes |
| out_byte_en | output | 8 | Store byte enables |
| out_reg_we | output | 1 | Register write allowed |
| out_mem_we | output | 1 | Memory write allowed |
| out_trap | output | 1 | Access traps |
| out_cause | output | 6 | Trap cause code |

## Verification
The only state in the block is the output register. A wrong transform, legality decision or extension therefore shows up at the ports in the cycle right after the access is accepted. A wrong handshake shows as a lost or changed result while out_ready is held low. The bench sweeps every selector against every size, both directions and both signed settings, using several data patterns. It computes each expected bit from a source-bit mapping, so a single swapped lane or a wrong cause code fails at once. Feeding each legal result back through the same selector exposes any transform that is not its own inverse.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

  localparam int unsigned XDW     = 64;
  localparam int unsigned XNB     = XDW / 8;
  localparam int unsigned CAUSE_W = 6;

  localparam logic [CAUSE_W-1:0] CAUSE_WIDTH = 6'd32;
  localparam logic [CAUSE_W-1:0] CAUSE_RSVD  = 6'd33;

  typedef enum logic [3:0] {
    SL_IDENT  = 4'd0,
    SL_NIB8   = 4'd1,
    SL_BREV8  = 4'd2,
    SL_BSW16  = 4'd3,
    SL_BSW32  = 4'd4,
    SL_BSW64  = 4'd5,
    SL_HSW32  = 4'd6,
    SL_HREV64 = 4'd7,
    SL_WSW64  = 4'd8,
    SL_BREV16 = 4'd9,
    SL_BREV32 = 4'd10,
    SL_BREV64 = 4'd11,
    SL_RSV12  = 4'd12,
    SL_RSV13  = 4'd13,
    SL_RSV14  = 4'd14,
    SL_RSV15  = 4'd15
  } slot_e;

  // Size code: 0 = 1 byte, 1 = 2, 2 = 4, 3 = 8
  function automatic logic [XDW-1:0] size_mask(input logic [1:0] sz);
    logic [XDW-1:0] m;
    case (sz)
      2'd0:    m = 64'h0000_0000_0000_00FF;
      2'd1:    m = 64'h0000_0000_0000_FFFF;
      2'd2:    m = 64'h0000_0000_FFFF_FFFF;
      default: m = '1;
    endcase
    return m;
  endfunction

  function automatic logic [XNB-1:0] size_be(input logic [1:0] sz);
    logic [XNB-1:0] b;
    case (sz)
      2'd0:    b = 8'h01;
      2'd1:    b = 8'h03;
      2'd2:    b = 8'h0F;
      default: b = 8'hFF;
    endcase
    return b;
  endfunction

  // Size code a width-locked slot demands; per-byte slots return 2'd0 and are not consulted
  function automatic logic [1:0] locked_size(input slot_e s);
    logic [1:0] r;
    case (s)
      SL_BSW16, SL_BREV16:                       r = 2'd1;
      SL_BSW32, SL_HSW32, SL_BREV32:             r = 2'd2;
      SL_BSW64, SL_HREV64, SL_WSW64, SL_BREV64:  r = 2'd3;
      default:                                   r = 2'd0;
    endcase
    return r;
  endfunction

  function automatic logic [XDW-1:0] byte_rev(input logic [XDW-1:0] d, input int unsigned nbytes);
    logic [XDW-1:0] r;
    r = '0;
    for (int i = 0; i < XNB; i++)
      if (i < nbytes) r[i*8 +: 8] = d[(nbytes-1-i)*8 +: 8];
    return r;
  endfunction

  function automatic logic [XDW-1:0] bit_rev(input logic [XDW-1:0] d, input int unsigned nbits);
    logic [XDW-1:0] r;
    r = '0;
    for (int i = 0; i < XDW; i++)
      if (i < nbits) r[i] = d[nbits-1-i];
    return r;
  endfunction

  function automatic logic [XDW-1:0] half_rev64(input logic [XDW-1:0] d);
    logic [XDW-1:0] r;
    for (int i = 0; i < 4; i++) r[i*16 +: 16] = d[(3-i)*16 +: 16];
    return r;
  endfunction

endpackage

// File: rtl/xlate_swizzle.sv
module xlate_swizzle
  import xlate_pkg::*;
(
  input  slot_e          sel,
  input  logic [XDW-1:0] din,
  output logic [XDW-1:0] dout
);

  logic [XDW-1:0] nib_lanes;
  logic [XDW-1:0] brv_lanes;

  for (genvar b = 0; b < XNB; b++) begin : g_lane
    assign nib_lanes[b*8 +: 8] = {din[b*8 +: 4], din[b*8+4 +: 4]};
    for (genvar k = 0; k < 8; k++) begin : g_bit
      assign brv_lanes[b*8+k] = din[b*8+7-k];
    end
  end

  // Input is already cut to the access size, so upper bytes are zero
  always_comb begin
    case (sel)
      SL_NIB8:   dout = nib_lanes;
      SL_BREV8:  dout = brv_lanes;
      SL_BSW16:  dout = byte_rev(din, 2);
      SL_BSW32:  dout = byte_rev(din, 4);
      SL_BSW64:  dout = byte_rev(din, 8);
      SL_HSW32:  dout = {32'b0, din[15:0], din[31:16]};
      SL_HREV64: dout = half_rev64(din);
      SL_WSW64:  dout = {din[31:0], din[63:32]};
      SL_BREV16: dout = bit_rev(din, 16);
      SL_BREV32: dout = bit_rev(din, 32);
      SL_BREV64: dout = bit_rev(din, 64);
      default:   dout = din;
    endcase
  end

endmodule

// File: rtl/xlate_legal.sv
module xlate_legal
  import xlate_pkg::*;
(
  input  slot_e              sel,
  input  logic [1:0]         size,
  output logic               trap,
  output logic [CAUSE_W-1:0] cause
);

  logic rsvd_hit;
  logic per_byte;
  logic width_bad;

  assign rsvd_hit  = (sel >= SL_RSV12);
  assign per_byte  = (sel <= SL_BREV8);
  assign width_bad = !rsvd_hit && !per_byte && (locked_size(sel) != size);

  // Reserved selector wins over the width check
  always_comb begin
    trap  = rsvd_hit || width_bad;
    cause = rsvd_hit ? CAUSE_RSVD : (width_bad ? CAUSE_WIDTH : '0);
  end

endmodule

// File: rtl/xlate_extend.sv
module xlate_extend
  import xlate_pkg::*;
(
  input  logic           is_store,
  input  logic           sgn,
  input  logic [1:0]     size,
  input  logic [XDW-1:0] din,
  output logic [XDW-1:0] dout
);

  always_comb begin
    if (is_store || !sgn) begin
      dout = din;
    end else begin
      case (size)
        2'd0:    dout = {{56{din[7]}},  din[7:0]};
        2'd1:    dout = {{48{din[15]}}, din[15:0]};
        2'd2:    dout = {{32{din[31]}}, din[31:0]};
        default: dout = din;
      endcase
    end
  end

endmodule

// File: rtl/mem_xlate_stage.sv
module mem_xlate_stage
  import xlate_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic               in_is_store,
  input  logic [1:0]         in_size,
  input  logic               in_signed,
  input  logic [3:0]         in_slot,
  input  logic               in_bypass,
  input  logic               in_rd_zero,
  input  logic [XDW-1:0]     in_data,
  output logic               out_valid,
  input  logic               out_ready,
  output logic               out_is_store,
  output logic [XDW-1:0]     out_data,
  output logic [XNB-1:0]     out_byte_en,
  output logic               out_reg_we,
  output logic               out_mem_we,
  output logic               out_trap,
  output logic [CAUSE_W-1:0] out_cause
);

  // Named internal events
  logic               acc;
  slot_e              eff_slot;
  logic [XDW-1:0]     trunc_data;
  logic [XDW-1:0]     swz_data;
  logic [XDW-1:0]     ext_data;
  logic               trap_now;
  logic [CAUSE_W-1:0] cause_now;

  assign in_ready   = !out_valid || out_ready;
  assign acc        = in_valid && in_ready;
  assign eff_slot   = in_bypass ? SL_IDENT : slot_e'(in_slot);
  assign trunc_data = in_data & size_mask(in_size);

  xlate_legal u_legal (
    .sel   (eff_slot),
    .size  (in_size),
    .trap  (trap_now),
    .cause (cause_now)
  );

  xlate_swizzle u_swz (
    .sel  (eff_slot),
    .din  (trunc_data),
    .dout (swz_data)
  );

  xlate_extend u_ext (
    .is_store (in_is_store),
    .sgn      (in_signed),
    .size     (in_size),
    .din      (swz_data),
    .dout     (ext_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_is_store <= 1'b0;
      out_data     <= '0;
      out_byte_en  <= '0;
      out_reg_we   <= 1'b0;
      out_mem_we   <= 1'b0;
      out_trap     <= 1'b0;
      out_cause    <= '0;
    end else if (acc) begin
      out_valid    <= 1'b1;
      out_is_store <= in_is_store;
      out_data     <= trap_now ? '0 : ext_data;
      out_byte_en  <= (trap_now || !in_is_store) ? '0 : size_be(in_size);
      out_reg_we   <= !trap_now && !in_is_store && !in_rd_zero;
      out_mem_we   <= !trap_now && in_is_store;
      out_trap     <= trap_now;
      out_cause    <= cause_now;
    end else if (out_ready) begin
      out_valid    <= 1'b0;
    end
  end

  // R8
  trap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_trap |-> !out_reg_we && !out_mem_we && out_data == '0 && out_byte_en == '0);

  // R5
  rsvd_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !in_bypass && in_slot >= 4'd12 |=> out_trap && out_cause == CAUSE_RSVD);

  // R10
  bypass_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_bypass |=> !out_trap && out_cause == '0);

  // R9
  rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !in_is_store && in_rd_zero |=> !out_reg_we);

  // R12
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_trap));

  // R3
  per_byte_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !in_bypass && in_slot <= 4'd2 |=> !out_trap);

  // R7
  store_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_mem_we |-> out_is_store && out_byte_en[0] && !out_trap);

endmodule

// File: tb/tb_mem_xlate_stage.sv
module tb_mem_xlate_stage;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_is_store = 1'b0;
  logic [1:0]  in_size = 2'd0;
  logic        in_signed = 1'b0;
  logic [3:0]  in_slot = 4'd0;
  logic        in_bypass = 1'b0;
  logic        in_rd_zero = 1'b0;
  logic [63:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_is_store;
  logic [63:0] out_data;
  logic [7:0]  out_byte_en;
  logic        out_reg_we;
  logic        out_mem_we;
  logic        out_trap;
  logic [5:0]  out_cause;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  mem_xlate_stage dut (.*);

  task automatic check(input string tag, input logic [95:0] got, input logic [95:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // Source bit for result bit j of a transform; -1 means a constant zero
  function automatic int src_of(input int s, input int j, input int nbits);
    if (j >= nbits) return -1;
    case (s)
      1: return j ^ 4;
      2: return (j & ~7) | (7 - (j & 7));
      3, 4, 5: return (nbits/8 - 1 - j/8) * 8 + (j % 8);
      6: return j ^ 16;
      7: return (3 - j/16) * 16 + (j % 16);
      8: return j ^ 32;
      9, 10, 11: return nbits - 1 - j;
      default: return j;
    endcase
  endfunction

  function automatic logic [95:0] model(input logic st, input int sz, input logic sg,
                                        input int sl, input logic byp, input logic rz,
                                        input logic [63:0] d);
    int nbits = 8 << sz;
    int s = byp ? 0 : sl;
    int need;
    logic trap;
    logic [5:0] cause;
    logic [63:0] r;
    logic [7:0] be;
    need = (s == 3 || s == 9) ? 1 : (s == 4 || s == 6 || s == 10) ? 2 : 3;
    trap = 1'b0; cause = 6'd0;
    if (s >= 12) begin trap = 1'b1; cause = 6'd33; end
    else if (s >= 3 && need != sz) begin trap = 1'b1; cause = 6'd32; end
    r = '0;
    for (int j = 0; j < 64; j++) begin
      int k = src_of(s, j, nbits);
      if (k >= 0) r[j] = d[k];
    end
    if (!st && sg && sz < 3)
      for (int j = nbits; j < 64; j++) r[j] = r[nbits-1];
    be = st ? 8'((1 << (1 << sz)) - 1) : 8'h00;
    if (trap) begin r = '0; be = 8'h00; end
    return {20'b0, r, be, !trap && !st && !rz, !trap && st, trap, cause};
  endfunction

  function automatic logic [95:0] grab();
    return {20'b0, out_data, out_byte_en, out_reg_we, out_mem_we, out_trap, out_cause};
  endfunction

  task automatic op(input logic st, input int sz, input logic sg, input int sl,
                    input logic byp, input logic rz, input logic [63:0] d);
    @(negedge clk);
    in_valid = 1'b1; in_is_store = st; in_size = 2'(sz); in_signed = sg;
    in_slot = 4'(sl); in_bypass = byp; in_rd_zero = rz; in_data = d;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic string tag_for(input int sl, input int sz, input logic st);
    if (sl >= 12) return "R5";
    if (sl <= 2) return (sl == 0 && !st) ? "R6" : "R3";
    if ((sl == 3 || sl == 9) && sz != 1) return "R4";
    if ((sl == 4 || sl == 6 || sl == 10) && sz != 2) return "R4";
    if ((sl == 5 || sl == 7 || sl == 8 || sl == 11) && sz != 3) return "R4";
    return st ? "R7" : "R2";
  endfunction

  logic [63:0] pats [3] = '{64'h0123_4567_89AB_CDEF, 64'hF1E2_D3C4_B5A6_9788, 64'h8000_0001_7F80_00FF};

  initial begin
    #(4 * 100000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] held;
    repeat (3) @(negedge clk);
    // R1
    check("R1 reset", {94'b0, out_valid, in_ready}, {94'b0, 1'b0, 1'b1});
    rst_n = 1'b1;

    // R2 R3 R4 R5 R6 R7 R8 full sweep
    for (int p = 0; p < 3; p++)
      for (int sl = 0; sl < 16; sl++)
        for (int sz = 0; sz < 4; sz++)
          for (int st = 0; st < 2; st++)
            for (int sg = 0; sg < 2; sg++) begin
              op(st[0], sz, sg[0], sl, 1'b0, 1'b0, pats[p]);
              check($sformatf("%s sl=%0d sz=%0d st=%0d sg=%0d", tag_for(sl, sz, st[0]), sl, sz, st, sg),
                    grab(), model(st[0], sz, sg[0], sl, 1'b0, 1'b0, pats[p]));
            end

    // R8 trap output state explicitly
    op(1'b1, 0, 1'b0, 5, 1'b0, 1'b0, 64'hFF);
    check("R8 trap quiet", grab(), {20'b0, 64'b0, 8'b0, 1'b0, 1'b0, 1'b1, 6'd32});

    // R9 register 0 destination
    op(1'b0, 2, 1'b1, 4, 1'b0, 1'b1, 64'h8899_AABB);
    check("R9 rd0 legal", grab(), model(1'b0, 2, 1'b1, 4, 1'b0, 1'b1, 64'h8899_AABB));
    op(1'b0, 0, 1'b0, 4, 1'b0, 1'b1, 64'h12);
    check("R9 rd0 trap", grab(), model(1'b0, 0, 1'b0, 4, 1'b0, 1'b1, 64'h12));

    // R10 bypass on reserved and locked slots
    for (int sl = 0; sl < 16; sl++) begin
      op(1'b0, 0, 1'b1, sl, 1'b1, 1'b0, 64'hC3);
      check("R10 bypass", grab(), {20'b0, 64'hFFFF_FFFF_FFFF_FFC3, 8'h00, 1'b1, 1'b0, 1'b0, 6'd0});
    end

    // R11 each legal pairing undoes itself
    for (int sl = 0; sl < 12; sl++)
      for (int sz = 0; sz < 4; sz++) begin
        logic [63:0] mid;
        if (model(1'b1, sz, 1'b0, sl, 1'b0, 1'b0, 0)[6]) continue;
        op(1'b1, sz, 1'b0, sl, 1'b0, 1'b0, pats[1]);
        mid = out_data;
        op(1'b1, sz, 1'b0, sl, 1'b0, 1'b0, mid);
        check($sformatf("R11 sl=%0d sz=%0d", sl, sz), {32'b0, out_data},
              {32'b0, pats[1] & ((sz == 3) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (8 << sz)) - 1))});
      end

    // R12 stall and hold
    @(negedge clk); out_ready = 1'b0;
    op(1'b1, 2, 1'b0, 4, 1'b0, 1'b0, 64'h1122_3344);
    held = out_data;
    check("R12 latency", {32'b0, out_valid, in_ready, held[61:0]}, {32'b0, 1'b1, 1'b0, 62'h4433_2211});
    @(negedge clk);
    check("R12 hold", {32'b0, out_valid, in_ready, out_data[61:0]}, {32'b0, 1'b1, 1'b0, held[61:0]});
    out_ready = 1'b1;
    @(negedge clk);
    check("R12 drain", {94'b0, out_valid, in_ready}, {94'b0, 1'b0, 1'b1});

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule